// File: doc/BRIEF.md
# Selectable Bit-Rate Tick Generator

This block makes the timing strobes for a serial port clocked at 14.7456 MHz. A three-bit rate code picks one of eight prescaler divisors. The prescaler emits a one-clock strobe at sixteen times the bit rate, so the divisors cover bit rates from 115200 down to 1200 baud.

Two counters, each dividing by sixteen, run from that strobe. The transmit tick runs freely at the bit rate with a fixed phase. The receive tick is normally spaced the same way. When the receiver sees a start edge, it raises a resync request. That restarts the receive counter, so the next receive tick falls half a bit later, at the centre of the bit, and later ticks follow one bit apart.

Top module: `baud_tick_gen`

## Requirements
- R1: Rate codes 0 through 7 select divisors 8, 16, 24, 48, 96, 192, 384 and 768 in that order. Consecutive oversample strobes are exactly that many clocks apart.
- R2: After synchronous reset is released, the first oversample strobe is visible in the cycle after the divisor-th rising edge.
- R3: The transmit tick rises one clock after every sixteenth oversample strobe. The first one follows 16×divisor+1 edges after reset.
- R4: Without resync, the receive tick rises one clock after the 8th oversample strobe after reset (edge 8×divisor+1) and then repeats every 16 strobes.
- R5: A resync request clears the receive counter. A strobe that arrives in the same cycle as the request is not counted. The next receive tick rises one clock after the 8th following strobe, and later ticks come every 16 strobes.
- R6: A new rate code takes effect only at the next prescaler wrap. The interval already in progress finishes at the old divisor.
- R7: Each strobe and each tick is high for exactly one clock.
- R8: While reset is high, all three outputs are low and all counters are cleared.
- R9: A resync request does not move the transmit tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 14.7456 MHz |
| rst | input | 1 | Synchronous reset, active high |
| rateSel | input | 3 | Rate code, 0..7 |
| rxResync | input | 1 | Restart request from the receiver on a start edge |
| x16Strobe | output | 1 | One-clock strobe at 16x the bit rate |
| txTick | output | 1 | Free-running transmit bit tick |
| rxTick | output | 1 | Mid-bit receive tick |

## Verification
Every output is registered, so each result is due a fixed number of edges after its cause:
- The oversample strobe appears in the cycle after the divisor-th edge following reset.
- Each tick appears one edge after the strobe that triggers it, which puts the first transmit tick at edge 16×divisor+1 and the first receive tick at edge 8×divisor+1.
- A resync sampled at edge N clears the receive counter at N. The first receive tick is then due one edge after the eighth strobe seen after N.

The bench counts rising edges from reset release and drives and samples only on falling edges. It then compares the exact edge number of each event against these formulas, for all eight rate codes, for a rate change made mid-interval, and for a resync that lands on a strobe cycle.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  localparam int OVERSAMPLE = 16;
  localparam int SUB_W      = $clog2(OVERSAMPLE);

  // Strobes from control to datapath
  typedef struct packed {
    logic x16;     // prescaler wrap, one clock
    logic resync;  // receive counter restart
  } tickCtl_t;
endpackage

// File: rtl/baud_tick_ctrl.sv
module baud_tick_ctrl
  import baud_tick_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int MAX_DIV = 768,
  localparam int PRE_W = $clog2(MAX_DIV + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rateSel,
  input  logic             rxResync,
  output tickCtl_t         ctl
);
  // Code 0..2 -> 8,16,24; codes 3+ double from 48
  function automatic logic [PRE_W-1:0] divFor(input logic [SEL_W-1:0] s);
    int d;
    if (s < 3) d = 8 * (int'(s) + 1);
    else       d = 48 << (int'(s) - 3);
    return PRE_W'(d);
  endfunction

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] activeDiv;
  logic             strobeQ;
  logic             wrap;

  assign wrap = (preCnt == activeDiv - PRE_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt    <= '0;
      activeDiv <= divFor(rateSel);
      strobeQ   <= 1'b0;
    end else begin
      strobeQ <= wrap;
      if (wrap) begin
        preCnt    <= '0;
        activeDiv <= divFor(rateSel);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  assign ctl.x16    = strobeQ;
  assign ctl.resync = rxResync;
endmodule

// File: rtl/baud_tick_dp.sv
module baud_tick_dp
  import baud_tick_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  tickCtl_t ctl,
  output logic     txTick,
  output logic     rxTick
);
  localparam int LANES = 2;  // 0 = transmit, 1 = receive

  logic [LANES-1:0] ticks;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam logic [SUB_W-1:0] HIT =
      (g == 0) ? SUB_W'(OVERSAMPLE - 1) : SUB_W'(OVERSAMPLE / 2 - 1);
    localparam bit CAN_CLEAR = (g == 1);

    logic [SUB_W-1:0] subCnt;
    logic             tickQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        subCnt <= '0;
        tickQ  <= 1'b0;
      end else if (CAN_CLEAR && ctl.resync) begin
        subCnt <= '0;
        tickQ  <= 1'b0;
      end else begin
        if (ctl.x16) subCnt <= subCnt + SUB_W'(1);
        tickQ <= ctl.x16 && (subCnt == HIT);
      end
    end

    assign ticks[g] = tickQ;
  end

  assign txTick = ticks[0];
  assign rxTick = ticks[1];
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int MAX_DIV = 768
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rateSel,
  input  logic             rxResync,
  output logic             x16Strobe,
  output logic             txTick,
  output logic             rxTick
);
  tickCtl_t ctl;

  baud_tick_ctrl #(.SEL_W(SEL_W), .MAX_DIV(MAX_DIV)) u_ctrl (
    .clk(clk), .rst(rst), .rateSel(rateSel), .rxResync(rxResync), .ctl(ctl)
  );

  baud_tick_dp u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .txTick(txTick), .rxTick(rxTick)
  );

  assign x16Strobe = ctl.x16;
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk (
  input logic clk,
  input logic rst,
  input logic rxResync,
  input logic x16Strobe,
  input logic txTick,
  input logic rxTick
);
  // R7: single-clock pulses (the smallest divisor is 8, so strobes never abut)
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
    x16Strobe |=> !x16Strobe);
  a_r7_tx_single: assert property (@(posedge clk) disable iff (rst)
    txTick |=> !txTick);
  a_r7_rx_single: assert property (@(posedge clk) disable iff (rst)
    rxTick |=> !rxTick);
  // R3: a transmit tick always follows a strobe
  a_r3_tx_after_strobe: assert property (@(posedge clk) disable iff (rst)
    txTick |-> $past(x16Strobe));
  // R4: a receive tick always follows a strobe
  a_r4_rx_after_strobe: assert property (@(posedge clk) disable iff (rst)
    rxTick |-> $past(x16Strobe));
  // R5: a resync suppresses the receive tick in the next cycle
  a_r5_resync_quiet: assert property (@(posedge clk) disable iff (rst)
    rxResync |=> !rxTick);
endmodule

bind baud_tick_gen baud_tick_chk u_chk (
  .clk(clk), .rst(rst), .rxResync(rxResync),
  .x16Strobe(x16Strobe), .txTick(txTick), .rxTick(rxTick)
);

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rateSel = 3'd0;
  logic       rxResync = 1'b0;
  logic       x16Strobe, txTick, rxTick;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  baud_tick_gen u0 (
    .clk(clk), .rst(rst), .rateSel(rateSel), .rxResync(rxResync),
    .x16Strobe(x16Strobe), .txTick(txTick), .rxTick(rxTick)
  );

  // rate code, expected divisor
  localparam int VEC[8][2] = '{
    '{0, 8}, '{1, 16}, '{2, 24}, '{3, 48},
    '{4, 96}, '{5, 192}, '{6, 384}, '{7, 768}};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R8: outputs stay low during reset; released on a falling edge
  task automatic doReset(input int sel);
    @(negedge clk);
    rst = 1'b1; rateSel = 3'(sel); rxResync = 1'b0;
    repeat (4) @(negedge clk);
    check({x16Strobe, txTick, rxTick} == 3'b000, "R8 outputs low in reset",
          int'({x16Strobe, txTick, rxTick}), 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int dv, fs1, fs2, ft1, ft2, fr1, fr2, dbl, pt, pr, ps;
    int rxN, txN, bad, sIdx;
    int sTimes[3];

    // Table walk: R1 R2 R3 R4 R7
    for (int i = 0; i < 8; i++) begin
      dv = VEC[i][1];
      doReset(VEC[i][0]);
      fs1 = -1; fs2 = -1; ft1 = -1; ft2 = -1; fr1 = -1; fr2 = -1;
      dbl = 0; pt = 0; pr = 0; ps = 0;
      for (int c = 1; c <= 32 * dv + 8; c++) begin
        @(posedge clk); @(negedge clk);
        if (x16Strobe) begin if (fs1 < 0) fs1 = c; else if (fs2 < 0) fs2 = c; end
        if (txTick) begin if (ft1 < 0) ft1 = c; else if (ft2 < 0) ft2 = c; end
        if (rxTick) begin if (fr1 < 0) fr1 = c; else if (fr2 < 0) fr2 = c; end
        if ((txTick && pt != 0) || (rxTick && pr != 0) || (x16Strobe && ps != 0)) dbl = 1;
        pt = int'(txTick); pr = int'(rxTick); ps = int'(x16Strobe);
      end
      check(fs1 == dv, "R2 first strobe edge", fs1, dv);
      check(fs2 - fs1 == dv, "R1 strobe period", fs2 - fs1, dv);
      check(ft1 == 16 * dv + 1, "R3 first tx tick edge", ft1, 16 * dv + 1);
      check(ft2 - ft1 == 16 * dv, "R3 tx tick period", ft2 - ft1, 16 * dv);
      check(fr1 == 8 * dv + 1, "R4 first rx tick edge", fr1, 8 * dv + 1);
      check(fr2 - fr1 == 16 * dv, "R4 rx tick period", fr2 - fr1, 16 * dv);
      check(dbl == 0, "R7 single-clock pulses", dbl, 0);
    end

    // R5 / R9: resync at edge 201, where a strobe is present and gets dropped.
    // Receive ticks are expected at edges 65, 193, 265 and 393;
    // transmit ticks at 129, 257 and 385, unaffected by the resync.
    doReset(0);
    rxN = 0; txN = 0; bad = 0;
    for (int c = 1; c <= 400; c++) begin
      @(posedge clk); @(negedge clk);
      if (rxTick) begin
        rxN++;
        if (!(c == 65 || c == 193 || c == 265 || c == 393)) begin
          bad++;
          check(0, "R5 rx tick at unexpected edge", c, 265);
        end
      end
      if (txTick) begin
        txN++;
        if (!(c == 129 || c == 257 || c == 385)) begin
          bad++;
          check(0, "R9 tx tick moved by resync", c, 257);
        end
      end
      rxResync = (c == 200);
    end
    check(rxN == 4, "R5 rx tick count around resync", rxN, 4);
    check(txN == 3, "R9 tx tick count around resync", txN, 3);

    // R6: switch from divisor 8 to 16 after edge 100.
    // The interval in progress still ends at edge 104; later strobes come at 120 and 136.
    doReset(0);
    sIdx = 0;
    for (int c = 1; c <= 150; c++) begin
      @(posedge clk); @(negedge clk);
      if (x16Strobe && c > 100 && sIdx < 3) begin sTimes[sIdx] = c; sIdx++; end
      if (c == 100) rateSel = 3'd1;
    end
    check(sIdx == 3, "R6 strobes after rate change", sIdx, 3);
    check(sTimes[0] == 104, "R6 old interval completes", sTimes[0], 104);
    check(sTimes[1] == 120, "R6 new divisor applied", sTimes[1], 120);
    check(sTimes[2] == 136, "R6 new period held", sTimes[2], 136);

    // R8: a reset in mid-run clears everything
    doReset(2);
    check({x16Strobe, txTick, rxTick} == 3'b000, "R8 low right after release",
          int'({x16Strobe, txTick, rxTick}), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule